// File: doc/BRIEF.md
# Two-Way Branch Target Buffer

This block remembers where taken branches went, so that an instruction fetch stage can steer to the predicted destination before the branch is decoded. It holds 4096 entries, organised as 2048 sets of two ways. The set is picked by fetch-address bits 15 down to 5, and the address bits above bit 15 form the tag. Each entry stores the complete target address.

A fetch address presented on the lookup port produces, in the same cycle, a hit flag, the stored target and the way that matched. When a branch resolves, its address and target go in on the update port. If the address already has an entry, that entry is refreshed in place. Otherwise a new entry is allocated: an empty way is used first, and when the set has no empty way the least-recently-used way is replaced. One bit per set tracks recency.

A synchronous flush empties the whole table in one cycle. A small occupancy state machine drives the full and empty flags from a count of valid entries. Its states are OCC_EMPTY, OCC_PARTIAL and OCC_FULL. It has these transitions:
- OCC_EMPTY to OCC_PARTIAL on the first allocation.
- OCC_PARTIAL to OCC_FULL when the count reaches 4096.
- OCC_PARTIAL to OCC_EMPTY, and OCC_FULL to OCC_EMPTY, on flush.

The machine stays in OCC_FULL through in-place refreshes and replacements, because neither changes the count.

Top module: `branch_target_buffer`

## Requirements
- R1: In the same cycle that `lk_pc` is presented, `lk_hit` is 1 exactly when set `lk_pc[15:5]` holds a valid entry whose tag equals `lk_pc[PC_W-1:16]`. On a hit, `lk_target` is that entry's stored full target and `lk_way` is its way (0 or 1). `lk_pc[4:0]` has no effect.
- R2: There are 2048 sets of 2 ways each. Two addresses that differ only in their tag can both be held in one set. Installing an entry in one set leaves the entries of every other set unchanged.
- R3: An update whose `up_pc` already hits overwrites the target in the way that matched. It never creates a second copy of the entry.
- R4: An update that misses allocates way 0 if way 0 is invalid. Otherwise it allocates way 1 if way 1 is invalid. If both are valid, it replaces the set's least-recently-used way.
- R5: Two events make a way most recent: a lookup that hits while `lk_valid` is 1, and an update written to that way. A lookup with `lk_valid` at 0 leaves recency unchanged. When an update and a lookup touch the same set in one cycle, the update wins.
- R6: An update is written at the clock edge and is visible to lookups from the next cycle on. A lookup in the same cycle sees the previous contents.
- R7: `empty` is 1 exactly when no entry is valid, and `full` is 1 exactly when all 4096 entries are valid. Both flags change on the edge that changes the occupancy. In-place refreshes and replacements leave `full` set.
- R8: `flush` invalidates every entry at the next edge. An update presented in the same cycle is discarded.
- R9: After reset every entry is invalid, `empty` is 1, `full` is 0 and all lookups miss.
- R10: Every one of the 4096 entry positions can be written through the update port and read back through the lookup port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries at the next edge |
| lk_valid | input | 1 | Lookup is a real fetch, so a hit updates recency |
| lk_pc | input | PC_W | Fetch address to look up |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_target | output | PC_W | Predicted target (zero on a miss) |
| lk_way | output | 1 | Way that matched |
| up_valid | input | 1 | Resolved branch to install or refresh |
| up_pc | input | PC_W | Address of the resolved branch |
| up_target | input | PC_W | Resolved target address |
| full | output | 1 | All 4096 entries valid |
| empty | output | 1 | No entry valid |

## Verification
The hardest condition to reach from the ports is OCC_FULL. Reaching it takes an update for every one of the 4096 positions, and none of those updates may land on an address that is already held. The bench fills the table by giving each set two computed tags that cannot collide. Just before the final install it confirms that `full` is still clear, and just after it confirms that `full` is set. It then reads back every position and checks the way and the arithmetic target. Recency is the other subtle case. It is checked with update sequences in which the victim way exposes whether a lookup with `lk_valid` low touched recency or left it unchanged.

// File: rtl/btb_pkg.sv
`timescale 1ns/1ps
package btb_pkg;
    localparam int IDX_LO   = 5;
    localparam int IDX_W    = 11;
    localparam int SETS     = 1 << IDX_W;
    localparam int WAYS     = 2;
    localparam int WAY_W    = $clog2(WAYS);
    localparam int CAPACITY = SETS * WAYS;
    localparam int CNT_W    = $clog2(CAPACITY + 1);

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PARTIAL,
        OCC_FULL
    } occ_state_t;
endpackage

// File: rtl/btb_way_store.sv
`timescale 1ns/1ps
module btb_way_store #(
    parameter int SETS  = 2048,
    parameter int IDX_W = 11,
    parameter int TAG_W = 16,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] rda_idx,
    output logic             rda_valid,
    output logic [TAG_W-1:0] rda_tag,
    output logic [PC_W-1:0]  rda_target,
    input  logic [IDX_W-1:0] rdb_idx,
    output logic             rdb_valid,
    output logic [TAG_W-1:0] rdb_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target
);
    logic [SETS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic [PC_W-1:0]  tgt_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

    assign rda_valid  = valid_q[rda_idx];
    assign rda_tag    = tag_q[rda_idx];
    assign rda_target = tgt_q[rda_idx];
    assign rdb_valid  = valid_q[rdb_idx];
    assign rdb_tag    = tag_q[rdb_idx];

    // R6
    write_marks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/btb_repl.sv
`timescale 1ns/1ps
module btb_repl #(
    parameter int SETS  = 2048,
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_touch,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic             lk_way,
    input  logic             up_touch,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             up_way,
    output logic             victim_way
);
    // lru_q[s] names the least-recently-used way of set s
    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else begin
            if (lk_touch) lru_q[lk_idx] <= ~lk_way;
            if (up_touch) lru_q[up_idx] <= ~up_way;
        end
    end

    assign victim_way = lru_q[up_idx];

    // R5
    update_recency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_touch |=> (lru_q[$past(up_idx)] == ~$past(up_way)));
endmodule

// File: rtl/btb_occ_fsm.sv
`timescale 1ns/1ps
module btb_occ_fsm
    import btb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic fill,
    output logic full,
    output logic empty
);
    localparam logic [CNT_W-1:0] CAP_L = CNT_W'(CAPACITY);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    occ_state_t       state_q, state_d;

    always_comb begin
        if (flush)     cnt_d = '0;
        else if (fill) cnt_d = cnt_q + 1'b1;
        else           cnt_d = cnt_q;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY:   if (!flush && fill) state_d = OCC_PARTIAL;
            OCC_PARTIAL: if (flush) state_d = OCC_EMPTY;
                         else if (cnt_d == CAP_L) state_d = OCC_FULL;
            OCC_FULL:    if (flush) state_d = OCC_EMPTY;
            default:     state_d = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        full  = (state_q == OCC_FULL);
        empty = (state_q == OCC_EMPTY);
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP_L);
    // R7
    full_matches_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full == (cnt_q == CAP_L));
    // R7
    empty_matches_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (cnt_q == '0));
    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
    // R7
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/branch_target_buffer.sv
`timescale 1ns/1ps
module branch_target_buffer
    import btb_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_target,
    output logic            lk_way,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic [PC_W-1:0] up_target,
    output logic            full,
    output logic            empty
);
    localparam int TAG_LO = IDX_LO + IDX_W;
    localparam int TAG_W  = PC_W - TAG_LO;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             low_bits_unused;

    assign lk_idx = lk_pc[TAG_LO-1:IDX_LO];
    assign lk_tag = lk_pc[PC_W-1:TAG_LO];
    assign up_idx = up_pc[TAG_LO-1:IDX_LO];
    assign up_tag = up_pc[PC_W-1:TAG_LO];
    assign low_bits_unused = ^{lk_pc[IDX_LO-1:0], up_pc[IDX_LO-1:0]};

    logic [WAYS-1:0]  lk_v, up_v, lk_hit_w, up_hit_w, wr_en_w;
    logic [TAG_W-1:0] lk_t [WAYS];
    logic [TAG_W-1:0] up_t [WAYS];
    logic [PC_W-1:0]  lk_tg [WAYS];
    logic             wr_go, wr_way, victim_way, fill;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        btb_way_store #(
            .SETS (SETS),
            .IDX_W(IDX_W),
            .TAG_W(TAG_W),
            .PC_W (PC_W)
        ) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .rda_idx   (lk_idx),
            .rda_valid (lk_v[w]),
            .rda_tag   (lk_t[w]),
            .rda_target(lk_tg[w]),
            .rdb_idx   (up_idx),
            .rdb_valid (up_v[w]),
            .rdb_tag   (up_t[w]),
            .wr_en     (wr_en_w[w]),
            .wr_idx    (up_idx),
            .wr_tag    (up_tag),
            .wr_target (up_target)
        );
        assign lk_hit_w[w] = lk_v[w] && (lk_t[w] == lk_tag);
        assign up_hit_w[w] = up_v[w] && (up_t[w] == up_tag);
        assign wr_en_w[w]  = wr_go && (wr_way == w[0]);
    end

    always_comb begin
        lk_hit    = |lk_hit_w;
        lk_way    = lk_hit_w[1];
        lk_target = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_hit_w[w]) lk_target = lk_tg[w];
        end
    end

    assign wr_go = up_valid && !flush;

    always_comb begin
        if (|up_hit_w)      wr_way = up_hit_w[1];
        else if (!up_v[0])  wr_way = 1'b0;
        else if (!up_v[1])  wr_way = 1'b1;
        else                wr_way = victim_way;
    end

    assign fill = wr_go && !(|up_hit_w) && !(&up_v);

    btb_repl #(
        .SETS (SETS),
        .IDX_W(IDX_W)
    ) u_repl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_touch  (lk_valid && lk_hit),
        .lk_idx    (lk_idx),
        .lk_way    (lk_way),
        .up_touch  (wr_go),
        .up_idx    (up_idx),
        .up_way    (wr_way),
        .victim_way(victim_way)
    );

    btb_occ_fsm u_occ (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(flush),
        .fill (fill),
        .full (full),
        .empty(empty)
    );

    // R3
    lookup_single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_w));
    // R3
    update_single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(up_hit_w));
    // R8
    flush_misses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);
    // R7
    full_excl_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: tb/test_branch_target_buffer.sv
`timescale 1ns/1ps
module test_branch_target_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit;
    logic [31:0] lk_target;
    logic        lk_way;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic [31:0] up_target = '0;
    logic        full, empty;

    int tests = 0;
    int fails = 0;

    branch_target_buffer #(.PC_W(32)) i_branch_target_buffer (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hit(lk_hit),
        .lk_target(lk_target), .lk_way(lk_way),
        .up_valid(up_valid), .up_pc(up_pc), .up_target(up_target),
        .full(full), .empty(empty)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] mk_pc(int set, int tag, int low);
        logic [31:0] s = set;
        logic [31:0] t = tag;
        logic [31:0] l = low;
        return {t[15:0], s[10:0], l[4:0]};
    endfunction

    function automatic logic [31:0] mk_tgt(logic [31:0] pc, int salt);
        return (pc ^ 32'h5A5A_3C3C) + 32'(salt) * 32'h0000_0104;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic upd(input logic [31:0] pc, input logic [31:0] tgt);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_target = tgt;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic look(input logic [31:0] pc, input bit lv, output bit hit,
                        output logic [31:0] tgt, output bit way);
        @(negedge clk);
        lk_pc = pc; lk_valid = lv;
        #1;
        hit = lk_hit; tgt = lk_target; way = lk_way;
        @(posedge clk);
        #1 lk_valid = 1'b0;
    endtask

    task automatic expect_hit(input logic [31:0] pc, input bit lv,
                              input logic [31:0] tgt, input bit way, input string req);
        bit h; bit w; logic [31:0] t;
        look(pc, lv, h, t, w);
        chk(h, {req, " hit"}, 32'(h), 32'd1);
        chk(t == tgt, {req, " target"}, t, tgt);
        chk(w == way, {req, " way"}, 32'(w), 32'(way));
    endtask

    task automatic expect_miss(input logic [31:0] pc, input string req);
        bit h; bit w; logic [31:0] t;
        look(pc, 1'b0, h, t, w);
        chk(!h, {req, " miss"}, 32'(h), 32'd0);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] a, b, c, d, e, f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state
        chk(empty == 1'b1, "R9 empty after reset", 32'(empty), 32'd1);
        chk(full == 1'b0, "R9 full after reset", 32'(full), 32'd0);
        expect_miss(mk_pc(5, 17, 0), "R9");

        a = mk_pc(5, 17, 0); b = mk_pc(5, 34, 0);
        c = mk_pc(5, 51, 0); d = mk_pc(5, 68, 0);
        e = mk_pc(6, 17, 0); f = mk_pc(7, 99, 0);

        // R6: same-cycle lookup sees old contents
        @(negedge clk);
        up_valid = 1'b1; up_pc = a; up_target = mk_tgt(a, 1); lk_pc = a;
        #1 chk(lk_hit == 1'b0, "R6 same-cycle lookup", 32'(lk_hit), 32'd0);
        @(negedge clk);
        up_valid = 1'b0;
        #1 chk(lk_hit == 1'b1, "R6 next-cycle lookup", 32'(lk_hit), 32'd1);
        chk(empty == 1'b0, "R7 empty clears", 32'(empty), 32'd0);
        expect_hit(a, 1'b0, mk_tgt(a, 1), 1'b0, "R4 first fill way0");
        // R1: low bits ignored
        expect_hit(mk_pc(5, 17, 31), 1'b0, mk_tgt(a, 1), 1'b0, "R1 low bits");

        // R2/R4: second tag in the same set goes to way 1
        upd(b, mk_tgt(b, 1));
        expect_hit(b, 1'b0, mk_tgt(b, 1), 1'b1, "R2 second way");
        expect_hit(a, 1'b0, mk_tgt(a, 1), 1'b0, "R2 first way kept");

        // R3: in-place refresh
        upd(a, mk_tgt(a, 2));
        expect_hit(a, 1'b0, mk_tgt(a, 2), 1'b0, "R3 refreshed target");
        expect_hit(b, 1'b0, mk_tgt(b, 1), 1'b1, "R3 other way intact");

        // R5: lk_valid low does not touch recency
        expect_hit(a, 1'b1, mk_tgt(a, 2), 1'b0, "R5 touch a");
        expect_hit(b, 1'b0, mk_tgt(b, 1), 1'b1, "R5 peek b");
        upd(c, mk_tgt(c, 1));
        expect_hit(c, 1'b0, mk_tgt(c, 1), 1'b1, "R5 victim is way1");
        expect_miss(b, "R5 evicted b");
        expect_hit(a, 1'b0, mk_tgt(a, 2), 1'b0, "R5 a kept");
        // R5: a real lookup touch steers the victim
        expect_hit(a, 1'b1, mk_tgt(a, 2), 1'b0, "R5 touch a again");
        upd(d, mk_tgt(d, 1));
        expect_hit(d, 1'b0, mk_tgt(d, 1), 1'b1, "R5 d replaces lru");
        expect_miss(c, "R5 evicted c");
        expect_hit(a, 1'b0, mk_tgt(a, 2), 1'b0, "R5 a survives");

        // R2: another set is independent
        upd(e, mk_tgt(e, 1));
        expect_hit(e, 1'b0, mk_tgt(e, 1), 1'b0, "R2 other set way0");
        expect_hit(a, 1'b0, mk_tgt(a, 2), 1'b0, "R2 set 5 untouched");

        // R8: flush wins over a same-cycle update
        @(negedge clk);
        flush = 1'b1; up_valid = 1'b1; up_pc = f; up_target = mk_tgt(f, 1);
        @(negedge clk);
        flush = 1'b0; up_valid = 1'b0;
        #1 chk(empty == 1'b1, "R8 empty after flush", 32'(empty), 32'd1);
        expect_miss(f, "R8 update discarded");
        expect_miss(a, "R8 entry cleared");

        // R10/R7: fill every position
        for (int s = 0; s < 2048; s++) begin
            upd(mk_pc(s, s + 1, 0), mk_tgt(mk_pc(s, s + 1, 0), 3));
            if (s == 2047) begin
                #1 chk(full == 1'b0, "R7 not full at 4095", 32'(full), 32'd0);
            end
            upd(mk_pc(s, s | 32'h8000, 0), mk_tgt(mk_pc(s, s | 32'h8000, 0), 4));
        end
        #1 chk(full == 1'b1, "R7 full at 4096", 32'(full), 32'd1);
        chk(empty == 1'b0, "R7 not empty when full", 32'(empty), 32'd0);
        for (int s = 0; s < 2048; s++) begin
            expect_hit(mk_pc(s, s + 1, 0), 1'b1, mk_tgt(mk_pc(s, s + 1, 0), 3),
                       1'b0, "R10 read way0");
            expect_hit(mk_pc(s, s | 32'h8000, 0), 1'b1,
                       mk_tgt(mk_pc(s, s | 32'h8000, 0), 4), 1'b1, "R10 read way1");
        end
        // R7: refresh and replacement keep full
        upd(mk_pc(9, 10, 0), mk_tgt(mk_pc(9, 10, 0), 7));
        #1 chk(full == 1'b1, "R7 full after refresh", 32'(full), 32'd1);
        expect_hit(mk_pc(9, 10, 0), 1'b0, mk_tgt(mk_pc(9, 10, 0), 7), 1'b0, "R3 refresh when full");
        upd(mk_pc(0, 12345, 0), mk_tgt(mk_pc(0, 12345, 0), 1));
        #1 chk(full == 1'b1, "R7 full after replace", 32'(full), 32'd1);
        expect_miss(mk_pc(3, 777, 0), "R1 absent tag");

        // R8: flush from full
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        #1 chk(empty == 1'b1, "R8 empty after flush", 32'(empty), 32'd1);
        chk(full == 1'b0, "R8 full cleared", 32'(full), 32'd0);
        for (int s = 0; s < 2048; s += 64) begin
            expect_miss(mk_pc(s, s + 1, 0), "R8 all cleared");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule